// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block drives a two-stage instruction pipeline. Every instruction cycle spans four clocks, called Q1 to Q4. While one instruction executes, the next one is fetched from program memory. The block holds the program counter, the instruction register, a valid flag for the executing slot and a small return-address stack. The ALU, the register file and full decoding are outside the block. A decoder next to it reports, through four inputs, whether the executing instruction jumps, calls or returns, and gives the target address.

Program memory returns the word at `pmem_addr_o` on `instr_i`. At the clock edge that closes Q4, that word moves into the instruction register and the program counter moves on. Because of this, the executing instruction in any cycle is always the word fetched in the cycle before. When an executing instruction changes the program counter, the word already fetched is marked invalid, and the next cycle runs as a NOP. A change of flow therefore costs two instruction cycles. The strobes for operand read and destination write fire only for valid instructions.

Top module: `qpipe_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the outputs are as follows: `pmem_addr_o` is 0, `q_o` is 4'b0001 (Q1), `ex_valid_o` is 0 and both strobes are low.
- R2: `q_o` is one-hot, with bit 0 for Q1 up to bit 3 for Q4. It advances one bit per clock in the order Q1, Q2, Q3, Q4 and then returns to Q1.
- R3: `pmem_addr_o` changes only at the edge that closes Q4. With no redirect, it increases by one at that edge, wrapping modulo 2^PC_W.
- R4: At the edge that closes Q4, the word on `instr_i` is loaded into the instruction register. It appears on `ir_o` for the whole next instruction cycle.
- R5: `rd_stb_o` is high exactly during Q2, and `wr_stb_o` exactly during Q4, of a cycle in which `ex_valid_o` is 1. Both strobes stay low in NOP cycles.
- R6: When `br_i` is taken, the program counter loads `target_i` and the next cycle is a NOP (`ex_valid_o` 0). In the cycle after that, the word at the target executes while the target plus one is fetched.
- R7: When `call_i` is taken, the current program counter is pushed onto the stack. This value is the address that follows the call. The program counter then loads `target_i`, and the next cycle is a NOP.
- R8: When `ret_i` is taken, the newest stack entry is popped into the program counter, and the next cycle is a NOP.
- R9: The stack holds 8 entries and is circular. A ninth push overwrites the oldest slot, without any flag. Pops walk backwards through the same ring.
- R10: `br_i`, `call_i`, `ret_i` and `target_i` are sampled only in Q4 of a cycle in which `ex_valid_o` is 1. In any other phase, and in NOP cycles, they have no effect.
- R11: If more than one control is asserted, call has priority over return, and return has priority over branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock; each rising edge advances one phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | INSTR_W | Program memory word at `pmem_addr_o` |
| br_i | input | 1 | Executing instruction jumps |
| call_i | input | 1 | Executing instruction calls |
| ret_i | input | 1 | Executing instruction returns |
| target_i | input | PC_W | Jump or call destination |
| pmem_addr_o | output | PC_W | Fetch address (program counter) |
| q_o | output | 4 | One-hot phase, bit 0 = Q1 |
| ex_valid_o | output | 1 | Executing slot holds a real instruction (0 = NOP) |
| ir_o | output | INSTR_W | Instruction register |
| rd_stb_o | output | 1 | Operand read strobe |
| wr_stb_o | output | 1 | Destination write strobe |

## Verification
Several properties are checked on every clock. The phase ring must close. The fetch address must hold between Q4 edges and step by one when no redirect happens. A taken jump or call must land on its target and must flush the following slot. A return must land on the stack entry it pops. The strobes must match their phase and validity. Only the bench scenarios, run against a behavioural model, can show three further points: that the instruction register carries the word fetched one cycle earlier; that the stack returns addresses in the correct order after it has wrapped past eight entries; and that control noise in other phases and in NOP cycles leaves the sequence unchanged.

// File: rtl/qpipe_pkg.sv
package qpipe_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
  typedef enum logic [1:0] {RD_SEQ, RD_JUMP, RD_CALL, RD_RET} redir_e;
endpackage

// File: rtl/qpipe_phase.sv
module qpipe_phase
  import qpipe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [3:0] q_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_Q1;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  for (genvar g = 0; g < 4; g++) begin : g_dec
    assign q_o[g] = (ph_q == phase_e'(g));
  end

  // R2
  ph_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[3] |=> q_o[0]);
  // R2
  ph_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q_o) == 1);
endmodule

// File: rtl/qpipe_rstack.sv
module qpipe_rstack #(
  parameter int DEPTH = 8,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] top_idx;

  assign top_idx = ptr_q - 1'b1;
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= din_i;   // wraps over oldest slot when full
      ptr_q        <= ptr_q + 1'b1;
    end else if (pop_i) begin
      ptr_q <= top_idx;
    end
  end

  // R9
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(din_i));
  // R9
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/qpipe_seq.sv
module qpipe_seq
  import qpipe_pkg::*;
#(
  parameter int PC_W        = 10,
  parameter int INSTR_W     = 14,
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               br_i,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic [PC_W-1:0]    target_i,
  output logic [PC_W-1:0]    pmem_addr_o,
  output logic [3:0]         q_o,
  output logic               ex_valid_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               rd_stb_o,
  output logic               wr_stb_o
);
  logic [PC_W-1:0]    pc_q, pc_nxt, stk_top;
  logic [INSTR_W-1:0] ir_q;
  logic               ir_vld_q;
  logic               take;
  redir_e             sel;

  qpipe_phase i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_o   (q_o)
  );

  // controls honoured only in Q4 of a real instruction
  assign take = q_o[3] && ir_vld_q;

  always_comb begin
    if      (take && call_i) sel = RD_CALL;
    else if (take && ret_i)  sel = RD_RET;
    else if (take && br_i)   sel = RD_JUMP;
    else                     sel = RD_SEQ;
  end

  always_comb begin
    unique case (sel)
      RD_CALL, RD_JUMP: pc_nxt = target_i;
      RD_RET:           pc_nxt = stk_top;
      default:          pc_nxt = pc_q + 1'b1;
    endcase
  end

  qpipe_rstack #(.DEPTH(STACK_DEPTH), .W(PC_W)) i_rstack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(sel == RD_CALL),
    .pop_i (sel == RD_RET),
    .din_i (pc_q),
    .top_o (stk_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      ir_vld_q <= 1'b0;
    end else if (q_o[3]) begin
      pc_q     <= pc_nxt;
      ir_q     <= instr_i;
      ir_vld_q <= (sel == RD_SEQ);  // redirect flushes the fetched word
    end
  end

  assign pmem_addr_o = pc_q;
  assign ir_o        = ir_q;
  assign ex_valid_o  = ir_vld_q;
  assign rd_stb_o    = ir_vld_q && q_o[1];
  assign wr_stb_o    = ir_vld_q && q_o[3];

  // R3
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[3] |=> $stable(pmem_addr_o));
  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && !(ex_valid_o && (br_i || call_i || ret_i)))
      |=> pmem_addr_o == PC_W'($past(pmem_addr_o) + 1'b1));
  // R6
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && ex_valid_o && (br_i || call_i || ret_i)) |=> !ex_valid_o);
  // R6
  jump_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && ex_valid_o && br_i && !call_i && !ret_i) |=> pmem_addr_o == $past(target_i));
  // R7
  call_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && ex_valid_o && call_i) |=> pmem_addr_o == $past(target_i));
  // R8
  ret_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && ex_valid_o && ret_i && !call_i) |=> pmem_addr_o == $past(stk_top));
  // R10
  vld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[3] |=> $stable(ex_valid_o));
  // R5
  rd_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> (q_o[1] && ex_valid_o));
  // R5
  wr_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (q_o[3] && ex_valid_o));
endmodule

// File: tb/test_qpipe_seq.sv
`timescale 1ns/1ps
module test_qpipe_seq;
  localparam int PC_W    = 10;
  localparam int INSTR_W = 14;
  localparam int NCYC    = 3000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [INSTR_W-1:0] instr;
  logic               br, call, ret;
  logic [PC_W-1:0]    target;
  logic [PC_W-1:0]    addr;
  logic [3:0]         q;
  logic               vld, rd, wr;
  logic [INSTR_W-1:0] ir;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit noise  = 0;

  always #2.5 clk = ~clk;

  qpipe_seq i_qpipe_seq (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .br_i(br), .call_i(call),
    .ret_i(ret), .target_i(target), .pmem_addr_o(addr), .q_o(q),
    .ex_valid_o(vld), .ir_o(ir), .rd_stb_o(rd), .wr_stb_o(wr)
  );

  // word: [13:12] op (0 seq, 1 jump, 2 call, 3 return), [11] assert all flags, [9:0] target
  function automatic logic [INSTR_W-1:0] prog_word(int a);
    if (a == 20)                                  return {2'd1, 2'b00, 10'd100};
    if (a == 105)                                 return {2'd2, 2'b00, 10'd200};
    if (a == 204)                                 return {2'd3, 2'b00, 10'd0};
    if (a == 110)                                 return {2'd2, 2'b00, 10'd300};
    if (a >= 300 && a <= 370 && a % 10 == 0)      return {2'd2, 2'b00, 10'(a + 10)};
    if (a == 380)                                 return {2'd3, 2'b00, 10'd0};
    if (a == 301)                                 return {2'd1, 2'b00, 10'd400};
    if (a >= 311 && a <= 371 && a % 10 == 1)      return {2'd3, 2'b00, 10'd0};
    if (a == 400)                                 return {2'd2, 2'b10, 10'd500};
    if (a == 500)                                 return {2'd3, 2'b00, 10'd0};
    if (a == 420)                                 return {2'd1, 2'b00, 10'd1020};
    return {2'd0, 2'b01, 10'(a) ^ 10'h2a5};
  endfunction

  assign instr = prog_word(int'(addr));

  // behavioural reference
  int               m_ph, m_pc, m_sp, m_depth;
  bit               m_vld;
  logic [INSTR_W-1:0] m_ir;
  int               m_stk [8];
  string            m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_sp = 0; m_depth = 0; m_vld = 0; m_ir = '0; m_tag = "R1";
      foreach (m_stk[i]) m_stk[i] = 0;
    end else if (m_ph != 3) begin
      m_ph++;
    end else begin
      int op, nxt;
      bit all, redir;
      op = int'(m_ir[13:12]); all = m_ir[11];
      redir = 1;
      nxt   = (m_pc + 1) % 1024;
      m_tag = noise ? "R10" : "R3";
      if (m_vld && (op == 2 || all)) begin
        m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_depth++;
        nxt = int'(m_ir[9:0]); m_tag = all ? "R11" : "R7";
      end else if (m_vld && op == 3) begin
        m_tag = (m_depth > 8) ? "R9" : "R8";
        m_sp = (m_sp + 7) % 8; m_depth--; nxt = m_stk[m_sp];
      end else if (m_vld && op == 1) begin
        nxt = int'(m_ir[9:0]); m_tag = "R6";
      end else redir = 0;
      m_ir  = prog_word(m_pc);
      m_vld = !redir;
      m_pc  = nxt;
      m_ph  = 0;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    t = rst_n ? "" : "R1";
    chk(q == 4'(1 << m_ph), (t != "") ? t : "R2", "phase", int'(q), 1 << m_ph);
    chk(int'(addr) == m_pc, (t != "") ? t : m_tag, "fetch address", int'(addr), m_pc);
    chk(vld == m_vld, (t != "") ? t : (noise ? "R10" : "R6"), "ex_valid", int'(vld), int'(m_vld));
    if (m_vld) chk(ir == m_ir, "R4", "instruction register", int'(ir), int'(m_ir));
    chk(rd == (m_vld && m_ph == 1), (t != "") ? t : "R5", "read strobe", int'(rd), int'(m_vld && m_ph == 1));
    chk(wr == (m_vld && m_ph == 3), (t != "") ? t : "R5", "write strobe", int'(wr), int'(m_vld && m_ph == 3));
  endtask

  task automatic drive();
    int op;
    bit all;
    op = int'(m_ir[13:12]); all = m_ir[11];
    if (m_ph == 3 && m_vld) begin
      br = (op == 1) || all; call = (op == 2) || all; ret = (op == 3) || all;
      target = m_ir[9:0];
    end else if (noise) begin
      br = $urandom_range(0, 1) == 1; call = $urandom_range(0, 1) == 1;
      ret = $urandom_range(0, 1) == 1; target = PC_W'($urandom);
    end else begin
      br = 0; call = 0; ret = 0; target = '0;
    end
  endtask

  initial begin
    rst_n = 0; br = 0; call = 0; ret = 0; target = '0;
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      compare();
      if (c == 1200) noise = 1;
      if (c == 2400) noise = 0;
      if (c == 1800) rst_n = 0;   // R1 mid-run reset
      if (c == 1803) rst_n = 1;
      drive();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule